// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits next to one processor and decides which interrupt that processor sees. A fixed number of external request lines arrive, each with a 24-bit source number and an 8-bit priority. Numerically lower priority values are more urgent, and 0xFF is the least urgent value. The block holds the processor's current priority. It raises its interrupt output whenever some request that is not already in service has a priority value strictly below the current priority. An internal slot carries the inter-processor interrupt on the fixed source number 2. That slot's priority is a byte that software writes.

Software reaches the block over a small 32-bit bus with word addressing and byte-lane enables. Every access is taken in the idle state and acknowledged one cycle later. The four words are: a side-effect-free view of the take word, the take word itself, a reserved word, and the IPI word. Reading the take word returns the old priority and the winning source in one word. The read also lifts the current priority to the winner's priority and marks the winner as in service. Writing a full word back to the same register ends service for the named source and restores the priority byte. The bus controller is a two-state machine. ST_IDLE takes an access when the select is high and moves to ST_ACK. ST_ACK drives the acknowledge for one cycle and always returns to ST_IDLE, ignoring the select.

Top module: `irq_presenter`

## Requirements
- R1: After reset the current priority is 0x00, the IPI byte is 0xFF and no source is in service. The interrupt output stays low even while requests are applied, a view read returns 0x00000000, and an IPI read returns 0xFF000000.
- R2: The interrupt output is high exactly when a request that is not in service has a priority value strictly below the current priority. A request whose priority equals the current priority is not presented.
- R3: A read of word 0 (bus_word_addr 2'b00) returns the current priority in bits 31:24 and the winning source number in bits 23:0, or 0 when no request is presented. It changes no state.
- R4: A read of word 1 (take word) while a request is presented returns {old current priority, winner source}. The current priority then becomes the winner's priority, and the winner is not presented again until its service ends.
- R5: A take-word read with no presented request returns {current priority, 0x000000} and changes no state.
- R6: The winner is the presented request with the lowest priority value. Among equal priorities, the lowest source number wins, whatever slot it arrives on.
- R7: A write to word 1 with lane 3 (bus_be[3], bits 31:24) enabled and any other lane disabled sets the current priority from bits 31:24 and ends no service. A write to word 1 with lane 3 disabled does not change the current priority.
- R8: A write to word 1 with all four lanes enabled sets the current priority from bits 31:24. It also ends service for every slot whose source number equals bits 23:0. A slot that is still requesting is then presented again. A write naming another number leaves in-service slots untouched.
- R9: Word 3 holds the IPI byte in bits 31:24, written only through lane 3 and read back as {byte, 0x000000}. Any value other than 0xFF requests source 2 at that priority, and 0xFF withdraws it. External sources must not use numbers 0 or 2.
- R10: An access is taken in ST_IDLE when bus_sel is high. bus_ack is high in the next cycle only, with read data valid there. Writes to words 0 and 2 are ignored, and word 2 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | N_SRC | Level request per external slot |
| src_num | input | N_SRC*24 | Source number per slot, slot i in bits 24*i+23:24*i |
| src_prio | input | N_SRC*8 | Priority per slot, slot i in bits 8*i+7:8*i |
| bus_sel | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 2 | Word index: 0 view, 1 take, 2 reserved, 3 IPI |
| bus_be | input | 4 | Byte-lane enables, lane 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with its default of four external slots. Two of those slots carry equal priorities and source numbers that run opposite to the slot order, which puts the lowest-number tie-break across slots within reach. With four slots plus the IPI slot, the bench can also exercise an unmatched end-of-service write, re-presentation of a still-requesting source, and the IPI winning at priority 0 against external sources.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;

    localparam logic [SRC_W-1:0]  SRC_NONE   = '0;
    localparam logic [SRC_W-1:0]  SRC_IPI    = SRC_W'(2);
    localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;
    localparam logic [PRIO_W-1:0] PRIO_RESET = '0;

    typedef enum logic [1:0] {
        REG_VIEW  = 2'd0,
        REG_TAKE  = 2'd1,
        REG_RSVD  = 2'd2,
        REG_IPI   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  num;
    } rank_t;
endpackage

// File: rtl/irqp_slot.sv
module irqp_slot
    import irqp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [SRC_W-1:0] num,
    input  logic             take,
    input  logic             eoi,
    input  logic [SRC_W-1:0] eoi_num,
    output logic             pending
);
    logic insvc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insvc_q <= 1'b0;
        end else if (take) begin
            insvc_q <= 1'b1;
        end else if (eoi && (eoi_num == num)) begin
            insvc_q <= 1'b0;
        end
    end

    assign pending = req && !insvc_q;
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter
    import irqp_pkg::*;
#(
    parameter int NSLOT = 5,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT-1:0]              pending,
    input  logic [NSLOT-1:0][PRIO_W-1:0]  prio,
    input  logic [NSLOT-1:0][SRC_W-1:0]   num,
    input  logic [PRIO_W-1:0]             cppr,
    output logic                          win_valid,
    output logic [IDX_W-1:0]              win_idx,
    output logic [PRIO_W-1:0]             win_prio,
    output logic [SRC_W-1:0]              win_num
);
    rank_t best;
    rank_t cand;

    always_comb begin
        best      = '1;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            cand = '{prio: prio[i], num: num[i]};
            if (pending[i] && (prio[i] < cppr) && (!win_valid || (cand < best))) begin
                best      = cand;
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
        win_prio = best.prio;
        win_num  = best.num;
    end
endmodule

// File: rtl/irqp_busfsm.sv
module irqp_busfsm
    import irqp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_word_addr,
    input  logic [3:0]        bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              win_valid,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic [SRC_W-1:0]  win_num,
    output logic              take,
    output logic              eoi,
    output logic [SRC_W-1:0]  eoi_num,
    output logic [PRIO_W-1:0] cppr,
    output logic [PRIO_W-1:0] ipi_prio,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ack
);
    bus_state_e        state_q, state_d;
    reg_sel_e          reg_sel;
    logic              acc;
    logic              cppr_wr;
    logic              ipi_wr;
    logic [WORD_W-1:0] rd_nxt;
    logic [PRIO_W-1:0] cppr_q, ipi_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] view_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        acc       = 1'b0;
        take      = 1'b0;
        eoi       = 1'b0;
        cppr_wr   = 1'b0;
        ipi_wr    = 1'b0;
        rd_nxt    = '0;
        reg_sel   = reg_sel_e'(bus_word_addr);
        view_word = {cppr_q, (win_valid ? win_num : SRC_NONE)};
        unique case (state_q)
            ST_IDLE: begin
                if (bus_sel) begin
                    acc     = 1'b1;
                    state_d = ST_ACK;
                end
            end
            ST_ACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (acc) begin
            unique case (reg_sel)
                REG_VIEW: rd_nxt = view_word;
                REG_TAKE: begin
                    if (bus_we) begin
                        cppr_wr = bus_be[3];
                        eoi     = (bus_be == 4'hF);
                    end else begin
                        rd_nxt = view_word;
                        take   = win_valid;
                    end
                end
                REG_RSVD: rd_nxt = '0;
                REG_IPI: begin
                    if (bus_we) ipi_wr = bus_be[3];
                    else        rd_nxt = {ipi_q, SRC_NONE};
                end
                default: rd_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cppr_q  <= PRIO_RESET;
            ipi_q   <= PRIO_LEAST;
            rdata_q <= '0;
        end else begin
            if (take)         cppr_q <= win_prio;
            else if (cppr_wr) cppr_q <= bus_wdata[WORD_W-1 -: PRIO_W];
            if (ipi_wr)       ipi_q  <= bus_wdata[WORD_W-1 -: PRIO_W];
            if (acc && !bus_we) rdata_q <= rd_nxt;
        end
    end

    assign eoi_num   = bus_wdata[SRC_W-1:0];
    assign cppr      = cppr_q;
    assign ipi_prio  = ipi_q;
    assign bus_rdata = rdata_q;
    assign bus_ack   = (state_q == ST_ACK);
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int NSLOT = N_SRC + 1,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_req,
    input  logic [N_SRC*SRC_W-1:0]  src_num,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [1:0]              bus_word_addr,
    input  logic [3:0]              bus_be,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic                    bus_ack,
    output logic                    irq_o
);
    logic [NSLOT-1:0]             slot_req;
    logic [NSLOT-1:0][SRC_W-1:0]  slot_num;
    logic [NSLOT-1:0][PRIO_W-1:0] slot_prio;
    logic [NSLOT-1:0]             slot_pend;
    logic                         win_valid;
    logic [IDX_W-1:0]             win_idx;
    logic [PRIO_W-1:0]            win_prio;
    logic [SRC_W-1:0]             win_num;
    logic                         take;
    logic                         eoi;
    logic [SRC_W-1:0]             eoi_num;
    logic [PRIO_W-1:0]            cppr_q;
    logic [PRIO_W-1:0]            ipi_prio;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < N_SRC) begin : g_ext
            assign slot_req[i]  = src_req[i];
            assign slot_num[i]  = src_num[i*SRC_W +: SRC_W];
            assign slot_prio[i] = src_prio[i*PRIO_W +: PRIO_W];
        end else begin : g_ipi
            assign slot_req[i]  = (ipi_prio != PRIO_LEAST);
            assign slot_num[i]  = SRC_IPI;
            assign slot_prio[i] = ipi_prio;
        end
        irqp_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (slot_req[i]),
            .num     (slot_num[i]),
            .take    (take && (win_idx == IDX_W'(i))),
            .eoi     (eoi),
            .eoi_num (eoi_num),
            .pending (slot_pend[i])
        );
    end

    irqp_arbiter #(.NSLOT(NSLOT)) u_arb (
        .pending   (slot_pend),
        .prio      (slot_prio),
        .num       (slot_num),
        .cppr      (cppr_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio),
        .win_num   (win_num)
    );

    irqp_busfsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_we        (bus_we),
        .bus_word_addr (bus_word_addr),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .win_valid     (win_valid),
        .win_prio      (win_prio),
        .win_num       (win_num),
        .take          (take),
        .eoi           (eoi),
        .eoi_num       (eoi_num),
        .cppr          (cppr_q),
        .ipi_prio      (ipi_prio),
        .bus_rdata     (bus_rdata),
        .bus_ack       (bus_ack)
    );

    assign irq_o = win_valid;
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [1:0]  bus_word_addr,
    input logic        bus_ack,
    input logic [23:0] rd_src,
    input logic        irq_o,
    input logic [7:0]  cppr
);
    logic take_rd;
    logic view_rd;

    assign take_rd = bus_sel && !bus_ack && !bus_we && (bus_word_addr == 2'd1);
    assign view_rd = bus_sel && !bus_ack && !bus_we && (bus_word_addr == 2'd0);

    AST_ACK_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_ack |=> bus_ack); // R10
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R10
    AST_ZERO_CPPR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cppr == 8'h00) |-> !irq_o); // R2
    AST_TAKE_GIVES_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd && irq_o |=> (rd_src != 24'h0)); // R4
    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd && !irq_o |=> (rd_src == 24'h0) && $stable(cppr)); // R5
    AST_VIEW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        view_rd |=> $stable(cppr)); // R3
endmodule

bind irq_presenter irqp_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_word_addr (bus_word_addr),
    .bus_ack       (bus_ack),
    .rd_src        (bus_rdata[23:0]),
    .irq_o         (irq_o),
    .cppr          (cppr_q)
);

// File: tb/irq_presenter_tb_top.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
    localparam int N_SRC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src_req = '0;
    logic [N_SRC*24-1:0] src_num = '0;
    logic [N_SRC*8-1:0]  src_prio = '0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_word_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack;
    logic              irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_presenter #(.N_SRC(N_SRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_num(src_num),
        .src_prio(src_prio), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_word_addr(bus_word_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq_o(irq_o)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word_addr = a; bus_be = 4'hF;
        @(negedge clk);
        bus_sel = 1'b0;
        if (bus_ack !== 1'b1) begin
            n_fail++;
            $display("FAIL R10: ack actual %0b expected 1", bus_ack);
        end
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic expect_view(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(2'd0, d);
        check32(tag, d, exp);
    endtask

    task automatic expect_take(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(2'd1, d);
        check32(tag, d, exp);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        expect_view("R1 view after reset", 32'h0000_0000);
        bus_read(2'd3, d);
        check32("R1 IPI byte after reset", d, 32'hFF00_0000);
        bus_read(2'd2, d);
        check32("R10 reserved word reads zero", d, 32'h0);
        expect_take("R5 spurious take at reset", 32'h0000_0000);
        src_num  = {24'h000005, 24'h000020, 24'h000011, 24'h000010};
        src_prio = {8'h03, 8'h03, 8'h03, 8'h05};
        src_req  = 4'b0001;
        @(negedge clk);
        check1("R1 irq masked by reset priority", irq_o, 1'b0);
    endtask

    task automatic t_open;
        bus_write(2'd1, 32'hFF00_0000, 4'b1000);
        @(negedge clk);
        check1("R7 byte write opens priority", irq_o, 1'b1);
        expect_view("R3 view shows winner", 32'hFF00_0010);
        expect_view("R3 view repeated unchanged", 32'hFF00_0010);
    endtask

    task automatic t_order;
        src_req = 4'b1111;
        expect_view("R6 tie goes to lowest number", 32'hFF00_0005);
    endtask

    task automatic t_take;
        expect_take("R4 take returns old priority and source", 32'hFF00_0005);
        expect_view("R4 priority raised to winner", 32'h0300_0000);
        check1("R2 equal priority not presented", irq_o, 1'b0);
        expect_take("R5 spurious take", 32'h0300_0000);
        expect_view("R5 no change after spurious", 32'h0300_0000);
    endtask

    task automatic t_strict;
        bus_write(2'd1, 32'h0400_0000, 4'b1000);
        @(negedge clk);
        check1("R2 strictly lower presented", irq_o, 1'b1);
        expect_view("R4 in-service source skipped", 32'h0400_0011);
        bus_write(2'd1, 32'h0300_0000, 4'b1000);
        @(negedge clk);
        check1("R2 equal priority masked", irq_o, 1'b0);
    endtask

    task automatic t_eoi;
        bus_write(2'd1, 32'hFF00_0005, 4'hF);
        expect_view("R8 still-requesting source re-presented", 32'hFF00_0005);
        src_req = 4'b0111;
        expect_view("R8 next winner after drop", 32'hFF00_0011);
        expect_take("R4 take second source", 32'hFF00_0011);
        bus_write(2'd1, 32'hFF00_0099, 4'hF);
        expect_view("R8 unmatched end keeps service", 32'hFF00_0020);
        bus_write(2'd1, 32'hFF00_0011, 4'hF);
        expect_view("R8 matched end releases", 32'hFF00_0011);
    endtask

    task automatic t_ipi;
        logic [31:0] d;
        bus_write(2'd3, 32'h0000_0000, 4'b1000);
        bus_read(2'd3, d);
        check32("R9 IPI byte readback", d, 32'h0000_0000);
        expect_view("R9 IPI presented on source 2", 32'hFF00_0002);
        expect_take("R9 IPI taken", 32'hFF00_0002);
        @(negedge clk);
        check1("R9 priority 0 masks all", irq_o, 1'b0);
        bus_write(2'd1, 32'hFF00_0002, 4'hF);
        expect_view("R9 IPI re-presented while requested", 32'hFF00_0002);
        bus_write(2'd3, 32'hFF00_0000, 4'b1000);
        expect_view("R9 IPI withdrawn", 32'hFF00_0011);
        bus_write(2'd3, 32'h00FF_FFFF, 4'b0111);
        bus_read(2'd3, d);
        check32("R9 IPI lanes 2..0 ignored", d, 32'hFF00_0000);
    endtask

    task automatic t_ignored;
        bus_write(2'd0, 32'h0000_0000, 4'hF);
        bus_write(2'd2, 32'h0000_0000, 4'hF);
        expect_view("R10 writes to words 0 and 2 ignored", 32'hFF00_0011);
        bus_write(2'd1, 32'h0000_0000, 4'b0100);
        expect_view("R7 lane 3 disabled keeps priority", 32'hFF00_0011);
    endtask

    task automatic t_ack;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word_addr = 2'd0;
        check1("R10 no ack in request cycle", bus_ack, 1'b0);
        @(negedge clk);
        check1("R10 ack one cycle later", bus_ack, 1'b1);
        bus_sel = 1'b0;
        @(negedge clk);
        check1("R10 ack lasts one cycle", bus_ack, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_open;
        t_order;
        t_take;
        t_strict;
        t_eoi;
        t_ipi;
        t_ignored;
        t_ack;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule